// File: doc/BRIEF.md
# Control and Status Register Bank

This block holds the 64-bit control and status registers of a noncacheable-unit style controller. Requests arrive on a simple one-cycle bus carrying a write flag, a byte size, a byte address, write data and the id of the requesting CPU. The bank holds an interrupt-management table indexed by device, a mondo vector register, fixed identity and status values, a set of error status, enable, injection and syndrome registers, and per-target mondo data and busy entries.

Every writable register keeps only its own set of writable bits. The mondo data and busy entries can be reached by an explicit per-target address or through alias addresses that pick the entry from the requester id. Only aligned 8-byte accesses are legal. Any other access, or an access to an unused offset, is answered with an error. The response comes one cycle after the request.

With default parameters a page is 0x200 bytes and holds one 64-bit word per 8 bytes. Page 0 (0x000) is the interrupt-management table. Page 1 (0x200) holds the single registers. Pages 2, 3 and 4 (0x400, 0x600, 0x800) are mondo data word 0, mondo data word 1 and mondo busy, each indexed by target. Page 5 (0xA00) holds the alias words.

Top module: `csr_bank`

## Requirements
- R1: A request whose size is not 8 bytes, or whose address has bits 2:0 nonzero, gets an error response with read data 0 and changes no register.
- R2: A request presented with req_valid at one rising edge gets exactly one response: rsp_valid, rsp_error and rsp_rdata are valid after that edge. When rsp_valid is low, rsp_error and rsp_rdata are 0. Write responses carry rsp_rdata 0.
- R3: A legal-size, aligned access to an unused offset returns an error and read data 0. Unused offsets are pages 6 and up, words 16 and up of page 1, and words 3 and up of page 5.
- R4: The interrupt-management entry at 0x000 + 8*i (i below the device count) resets to 0. Only bits 13:8 and 5:0 of the entry are writable.
- R5: The mondo vector register at 0x200 resets to 0 and keeps only bits 5:0 of a write.
- R6: Writes to the serial number (0x208, reads 0xDEADBEEF), the fuse status (0x210, reads all ones), the bank-enable status (0x228, reads 0x3CF) and the mondo data words (pages 2 and 3, read 0) are ignored and return no error.
- R7: The bank-available word (0x218) and the bank-enable word (0x220) both read 0xFF, and writes to them are ignored. The hash enable (0x230) and hash status (0x238) words always read 0.
- R8: The log enable (0x248) resets to 0x1FFFFFFF. The interrupt enable (0x250), injection (0x258) and fatal enable (0x260) registers reset to 0. All four keep only bits 42:0 of a write.
- R9: The error status (0x240) and the pending status (0x268) share one register. Its writable bits are 63 and 42:0, and a write through either address is seen through both.
- R10: The first syndrome register (0x270) keeps bits 63 and 58:0 of a write. The second (0x278) keeps bits 63:58 and 55:0.
- R11: The busy entry of target t is at 0x800 + 8*t. It resets to 0 and only bit 6 is writable.
- R12: The alias addresses 0xA00 (data word 0), 0xA08 (data word 1) and 0xA10 (busy) act on the entry of the target equal to req_cpu.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 4 | Access size in bytes |
| req_addr | input | ADDR_W (16) | Byte address within the bank |
| req_wdata | input | 64 | Write data |
| req_cpu | input | log2(NTGT) (6) | Id of the requesting CPU |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_error | output | 1 | Request rejected |
| rsp_rdata | output | 64 | Read data |

## Verification
On every cycle the assertions check the response timing and the quiet idle state of the outputs. They also check that bad sizes and misaligned addresses are flagged, that every error carries zero data, and that the fixed serial, hash, vector and busy read values hold. Other behaviour needs a sequence of accesses, so only the directed scenarios show it. This covers the per-register write masks, ignored writes to read-only words, the shared storage behind the status and pending-status addresses, and the alias words picking the entry from the requester id.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  localparam int DATA_W = 64;

  typedef enum logic [3:0] {
    RG_NONE, RG_INTMAN, RG_SCALAR, RG_DATA0, RG_DATA1,
    RG_BUSY, RG_ADATA0, RG_ADATA1, RG_ABUSY
  } region_e;

  // Word numbers inside the single-register page.
  typedef enum logic [3:0] {
    SC_VEC      = 4'd0,
    SC_SERIAL   = 4'd1,
    SC_FUSE     = 4'd2,
    SC_BANK_AVL = 4'd3,
    SC_BANK_EN  = 4'd4,
    SC_BANK_STS = 4'd5,
    SC_HASH_EN  = 4'd6,
    SC_HASH_STS = 4'd7,
    SC_ERR_STS  = 4'd8,
    SC_LOG_EN   = 4'd9,
    SC_INT_EN   = 4'd10,
    SC_INJECT   = 4'd11,
    SC_FATAL_EN = 4'd12,
    SC_PEND_STS = 4'd13,
    SC_SYN_A    = 4'd14,
    SC_SYN_B    = 4'd15
  } scalar_e;

  localparam logic [DATA_W-1:0] MASK_VEC   = 64'h0000_0000_0000_003F;
  localparam logic [DATA_W-1:0] MASK_ENA   = 64'h0000_07FF_FFFF_FFFF;
  localparam logic [DATA_W-1:0] MASK_ERR   = 64'h8000_07FF_FFFF_FFFF;
  localparam logic [DATA_W-1:0] MASK_SYN_A = 64'h87FF_FFFF_FFFF_FFFF;
  localparam logic [DATA_W-1:0] MASK_SYN_B = 64'hFCFF_FFFF_FFFF_FFFF;

  localparam logic [DATA_W-1:0] RST_SERIAL   = 64'h0000_0000_DEAD_BEEF;
  localparam logic [DATA_W-1:0] RST_FUSE     = '1;
  localparam logic [DATA_W-1:0] RST_BANK_EN  = 64'h0000_0000_0000_00FF;
  localparam logic [DATA_W-1:0] RST_BANK_STS = 64'h0000_0000_0000_03CF;
  localparam logic [DATA_W-1:0] RST_LOG_EN   = 64'h0000_0000_1FFF_FFFF;

  localparam int BUSY_BIT = 6;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/csr_req_decode.sv
module csr_req_decode
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PG_W   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output region_e           region,
  output scalar_e           word,
  output logic [PG_W-1:0]   idx,
  output logic              legal
);

  localparam int PAGE_LSB = 3 + PG_W;
  localparam int PN_W     = ADDR_W - PAGE_LSB;

  logic [PN_W-1:0] page;

  assign page = addr[ADDR_W-1:PAGE_LSB];
  assign idx  = addr[PAGE_LSB-1:3];
  assign word = scalar_e'(idx[3:0]);

  always_comb begin
    region = RG_NONE;
    case (page)
      PN_W'(0): region = RG_INTMAN;
      PN_W'(1): if (idx < PG_W'(16)) region = RG_SCALAR;
      PN_W'(2): region = RG_DATA0;
      PN_W'(3): region = RG_DATA1;
      PN_W'(4): region = RG_BUSY;
      PN_W'(5): begin
        if (idx == PG_W'(0))      region = RG_ADATA0;
        else if (idx == PG_W'(1)) region = RG_ADATA1;
        else if (idx == PG_W'(2)) region = RG_ABUSY;
      end
      default: region = RG_NONE;
    endcase
  end

  assign legal = (size == 4'd8) && (addr[2:0] == 3'b000) && (region != RG_NONE);

endmodule

// File: rtl/csr_intman_array.sv
module csr_intman_array #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [11:0]      wr_bits,
  output logic [63:0]      rd_data
);

  // Only the writable bits are stored: {13:8, 5:0}.
  logic [11:0] ent_q [N];
  logic [11:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[idx] <= wr_bits;
    end
  end

  assign cur     = ent_q[idx];
  assign rd_data = {50'b0, cur[11:6], 2'b00, cur[5:0]};

endmodule

// File: rtl/csr_busy_vec.sv
module csr_busy_vec
  import csr_bank_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_bit,
  output logic [63:0]      rd_data
);

  logic [N-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (rst)        busy_q      <= '0;
    else if (wr_en) busy_q[idx] <= wr_bit;
  end

  always_comb begin
    rd_data           = '0;
    rd_data[BUSY_BIT] = busy_q[idx];
  end

endmodule

// File: rtl/csr_scalar_regs.sv
module csr_scalar_regs
  import csr_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  scalar_e     word,
  input  logic [63:0] wdata,
  output logic [63:0] rd_data
);

  logic [63:0] vec_q, err_q, log_q, ien_q, inj_q, fat_q, syna_q, synb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      err_q  <= '0;
      log_q  <= RST_LOG_EN;
      ien_q  <= '0;
      inj_q  <= '0;
      fat_q  <= '0;
      syna_q <= '0;
      synb_q <= '0;
    end else if (wr_en) begin
      case (word)
        SC_VEC:                 vec_q  <= wdata & MASK_VEC;
        SC_ERR_STS, SC_PEND_STS: err_q <= wdata & MASK_ERR;
        SC_LOG_EN:              log_q  <= wdata & MASK_ENA;
        SC_INT_EN:              ien_q  <= wdata & MASK_ENA;
        SC_INJECT:              inj_q  <= wdata & MASK_ENA;
        SC_FATAL_EN:            fat_q  <= wdata & MASK_ENA;
        SC_SYN_A:               syna_q <= wdata & MASK_SYN_A;
        SC_SYN_B:               synb_q <= wdata & MASK_SYN_B;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (word)
      SC_VEC:                  rd_data = vec_q;
      SC_SERIAL:               rd_data = RST_SERIAL;
      SC_FUSE:                 rd_data = RST_FUSE;
      SC_BANK_AVL, SC_BANK_EN: rd_data = RST_BANK_EN;
      SC_BANK_STS:             rd_data = RST_BANK_STS;
      SC_ERR_STS, SC_PEND_STS: rd_data = err_q;
      SC_LOG_EN:               rd_data = log_q;
      SC_INT_EN:               rd_data = ien_q;
      SC_INJECT:               rd_data = inj_q;
      SC_FATAL_EN:             rd_data = fat_q;
      SC_SYN_A:                rd_data = syna_q;
      SC_SYN_B:                rd_data = synb_q;
      default:                 rd_data = '0;
    endcase
  end

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int NDEV   = 64,
  parameter int NTGT   = 64,
  parameter int ADDR_W = 16,
  localparam int TGT_W = $clog2(NTGT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [TGT_W-1:0]  req_cpu,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [63:0]       rsp_rdata
);

  localparam int DEV_W = $clog2(NDEV);
  localparam int PG_W  = max3(DEV_W, TGT_W, 4);

  region_e         region;
  scalar_e         word;
  logic [PG_W-1:0] idx;
  logic            legal;
  logic            wr_go;
  logic [TGT_W-1:0] busy_idx;
  logic [63:0]     im_rd, sc_rd, busy_rd, rd_mux;

  csr_req_decode #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_dec (
    .addr  (req_addr),
    .size  (req_size),
    .region(region),
    .word  (word),
    .idx   (idx),
    .legal (legal)
  );

  assign wr_go = req_valid && req_write && legal;

  csr_intman_array #(.N(NDEV), .IDX_W(DEV_W)) u_intman (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_go && (region == RG_INTMAN)),
    .idx    (idx[DEV_W-1:0]),
    .wr_bits({req_wdata[13:8], req_wdata[5:0]}),
    .rd_data(im_rd)
  );

  csr_scalar_regs u_scalar (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_go && (region == RG_SCALAR)),
    .word   (word),
    .wdata  (req_wdata),
    .rd_data(sc_rd)
  );

  assign busy_idx = (region == RG_ABUSY) ? req_cpu : idx[TGT_W-1:0];

  csr_busy_vec #(.N(NTGT), .IDX_W(TGT_W)) u_busy (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_go && ((region == RG_BUSY) || (region == RG_ABUSY))),
    .idx    (busy_idx),
    .wr_bit (req_wdata[BUSY_BIT]),
    .rd_data(busy_rd)
  );

  // Mondo data words have no writer inside the bank and read as zero.
  always_comb begin
    case (region)
      RG_INTMAN:         rd_mux = im_rd;
      RG_SCALAR:         rd_mux = sc_rd;
      RG_BUSY, RG_ABUSY: rd_mux = busy_rd;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_error <= req_valid && !legal;
      rsp_rdata <= (req_valid && !req_write && legal) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
  parameter int NDEV   = 64,
  parameter int NTGT   = 64,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [3:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_error,
  input logic [63:0]       rsp_rdata
);

  localparam int PG_W     = csr_bank_pkg::max3($clog2(NDEV), $clog2(NTGT), 4);
  localparam int PAGE_LSB = 3 + PG_W;
  localparam logic [ADDR_W-1:0] PAGE1 = ADDR_W'(1) << PAGE_LSB;
  localparam logic [ADDR_W-1:0] A_VEC    = PAGE1;
  localparam logic [ADDR_W-1:0] A_SERIAL = PAGE1 + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_HASHE  = PAGE1 + ADDR_W'(48);
  localparam logic [ADDR_W-1:0] A_HASHS  = PAGE1 + ADDR_W'(56);

  logic rd_ok;
  assign rd_ok = req_valid && !req_write && (req_size == 4'd8);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_extra_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_error && rsp_rdata == 64'd0));

  assert_bad_size_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size != 4'd8) |=> rsp_error);

  assert_misaligned_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[2:0] != 3'b000) |=> rsp_error);

  assert_error_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_error) |-> (rsp_rdata == 64'd0));

  assert_serial_value_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && req_addr == A_SERIAL) |=> (!rsp_error && rsp_rdata == 64'hDEAD_BEEF));

  assert_hash_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && (req_addr == A_HASHE || req_addr == A_HASHS)) |=> (rsp_rdata == 64'd0));

  assert_vec_width_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && req_addr == A_VEC) |=> (rsp_rdata[63:6] == 58'd0));

  assert_busy_bit_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && req_addr[ADDR_W-1:PAGE_LSB] == (ADDR_W-PAGE_LSB)'(4))
      |=> ((rsp_rdata & ~64'h40) == 64'd0));

endmodule

bind csr_bank csr_bank_chk #(.NDEV(NDEV), .NTGT(NTGT), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_size (req_size),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_error(rsp_error),
  .rsp_rdata(rsp_rdata)
);

// File: tb/csr_bank_tb.sv
module csr_bank_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_size = 4'd8;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [5:0]  req_cpu = '0;
  logic        rsp_valid;
  logic        rsp_error;
  logic [63:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [63:0] ONES = '1;

  always #2 clk = ~clk;

  csr_bank u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  // One request; response sampled on the falling edge after the capturing edge.
  task automatic xfer(input bit wr, input logic [3:0] sz, input logic [15:0] a,
                      input logic [63:0] d, input logic [5:0] cpu,
                      output logic err, output logic [63:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = a; req_wdata = d; req_cpu = cpu;
    @(negedge clk);
    check("R2 response strobe", {63'd0, rsp_valid}, 64'd1);
    err = rsp_error;
    q   = rsp_rdata;
    req_valid = 1'b0;
    @(negedge clk);
    check("R2 idle after response", {62'd0, rsp_valid, rsp_error}, 64'd0);
  endtask

  task automatic wr8(input logic [15:0] a, input logic [63:0] d, input logic [5:0] cpu,
                     input string tag);
    logic e; logic [63:0] q;
    xfer(1'b1, 4'd8, a, d, cpu, e, q);
    check(tag, {63'd0, e}, 64'd0);
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [5:0] cpu,
                           input logic [63:0] exp, input string tag);
    logic e; logic [63:0] q;
    xfer(1'b0, 4'd8, a, 64'd0, cpu, e, q);
    check(tag, {63'd0, e}, 64'd0);
    check(tag, q, exp);
  endtask

  task automatic expect_err(input bit wr, input logic [3:0] sz, input logic [15:0] a,
                            input logic [63:0] d, input string tag);
    logic e; logic [63:0] q;
    xfer(wr, sz, a, d, 6'd0, e, q);
    check(tag, {63'd0, e}, 64'd1);
    check(tag, q, 64'd0);
  endtask

  task automatic t_reset();
    check("R2 reset outputs", {rsp_error, rsp_valid, 62'd0} | rsp_rdata, 64'd0);
    rd_expect(16'h208, 0, 64'hDEAD_BEEF, "R6 serial reset");
    rd_expect(16'h210, 0, ONES, "R6 fuse reset");
    rd_expect(16'h228, 0, 64'h3CF, "R6 bank status reset");
    rd_expect(16'h248, 0, 64'h1FFF_FFFF, "R8 log enable reset");
    rd_expect(16'h250, 0, 64'd0, "R8 interrupt enable reset");
    rd_expect(16'h028, 0, 64'd0, "R4 table reset");
    rd_expect(16'h200, 0, 64'd0, "R5 vector reset");
    rd_expect(16'h818, 0, 64'd0, "R11 busy reset");
  endtask

  task automatic t_illegal();
    expect_err(1'b1, 4'd4, 16'h200, ONES, "R1 size 4 write");
    rd_expect(16'h200, 0, 64'd0, "R1 no change after bad size");
    expect_err(1'b1, 4'd8, 16'h204, ONES, "R1 misaligned write");
    rd_expect(16'h200, 0, 64'd0, "R1 no change after misaligned");
    expect_err(1'b0, 4'd8, 16'h20C, 64'd0, "R1 misaligned read");
    expect_err(1'b0, 4'd2, 16'h208, 64'd0, "R1 size 2 read");
    expect_err(1'b1, 4'd1, 16'h028, ONES, "R1 size 1 table write");
    rd_expect(16'h028, 0, 64'd0, "R1 table unchanged");
  endtask

  task automatic t_unmapped();
    expect_err(1'b0, 4'd8, 16'h280, 64'd0, "R3 page1 word16");
    expect_err(1'b0, 4'd8, 16'hC00, 64'd0, "R3 page6");
    expect_err(1'b0, 4'd8, 16'hA18, 64'd0, "R3 alias word3");
    expect_err(1'b1, 4'd8, 16'hF000, ONES, "R3 unmapped write");
  endtask

  task automatic t_intman();
    wr8(16'h028, ONES, 0, "R4 write idx5");
    wr8(16'h1F8, 64'hAAAA_AAAA_AAAA_AAAA, 0, "R4 write idx63");
    rd_expect(16'h028, 0, 64'h3F3F, "R4 idx5 mask");
    rd_expect(16'h1F8, 0, 64'h2A2A, "R4 idx63 mask");
    rd_expect(16'h030, 0, 64'd0, "R4 neighbour untouched");
  endtask

  task automatic t_vec();
    wr8(16'h200, ONES, 0, "R5 vector write");
    rd_expect(16'h200, 0, 64'h3F, "R5 vector mask");
    wr8(16'h200, 64'h15, 0, "R5 vector write2");
    rd_expect(16'h200, 0, 64'h15, "R5 vector value");
  endtask

  task automatic t_readonly();
    wr8(16'h208, 64'd0, 0, "R6 serial write no error");
    rd_expect(16'h208, 0, 64'hDEAD_BEEF, "R6 serial kept");
    wr8(16'h210, 64'd0, 0, "R6 fuse write");
    rd_expect(16'h210, 0, ONES, "R6 fuse kept");
    wr8(16'h228, 64'd0, 0, "R6 bank status write");
    rd_expect(16'h228, 0, 64'h3CF, "R6 bank status kept");
    wr8(16'h408, ONES, 0, "R6 data0 write");
    rd_expect(16'h408, 0, 64'd0, "R6 data0 reads zero");
    wr8(16'h608, ONES, 0, "R6 data1 write");
    rd_expect(16'h608, 0, 64'd0, "R6 data1 reads zero");
  endtask

  task automatic t_bank_hash();
    rd_expect(16'h218, 0, 64'hFF, "R7 bank available");
    wr8(16'h220, 64'd0, 0, "R7 bank enable write");
    rd_expect(16'h220, 0, 64'hFF, "R7 bank enable kept");
    rd_expect(16'h218, 0, 64'hFF, "R7 bank available kept");
    wr8(16'h230, ONES, 0, "R7 hash enable write");
    rd_expect(16'h230, 0, 64'd0, "R7 hash enable zero");
    rd_expect(16'h238, 0, 64'd0, "R7 hash status zero");
  endtask

  task automatic t_enables();
    wr8(16'h248, ONES, 0, "R8 log write");
    wr8(16'h250, ONES, 0, "R8 int write");
    wr8(16'h258, ONES, 0, "R8 inject write");
    wr8(16'h260, ONES, 0, "R8 fatal write");
    rd_expect(16'h248, 0, 64'h7FF_FFFF_FFFF, "R8 log mask");
    rd_expect(16'h250, 0, 64'h7FF_FFFF_FFFF, "R8 int mask");
    rd_expect(16'h258, 0, 64'h7FF_FFFF_FFFF, "R8 inject mask");
    rd_expect(16'h260, 0, 64'h7FF_FFFF_FFFF, "R8 fatal mask");
  endtask

  task automatic t_status();
    wr8(16'h268, ONES, 0, "R9 pending write");
    rd_expect(16'h240, 0, 64'h8000_07FF_FFFF_FFFF, "R9 status via main");
    rd_expect(16'h268, 0, 64'h8000_07FF_FFFF_FFFF, "R9 status via pending");
    wr8(16'h240, 64'h123, 0, "R9 main write");
    rd_expect(16'h268, 0, 64'h123, "R9 pending mirrors");
  endtask

  task automatic t_syndrome();
    wr8(16'h270, ONES, 0, "R10 syndrome A write");
    wr8(16'h278, ONES, 0, "R10 syndrome B write");
    rd_expect(16'h270, 0, 64'h87FF_FFFF_FFFF_FFFF, "R10 syndrome A mask");
    rd_expect(16'h278, 0, 64'hFCFF_FFFF_FFFF_FFFF, "R10 syndrome B mask");
  endtask

  task automatic t_busy();
    wr8(16'h838, ONES, 0, "R11 busy write t7");
    rd_expect(16'h838, 0, 64'h40, "R11 busy t7 bit6");
    rd_expect(16'h840, 0, 64'd0, "R11 busy t8 clear");
    wr8(16'h838, 64'hBF, 0, "R11 busy clear t7");
    rd_expect(16'h838, 0, 64'd0, "R11 busy t7 cleared");
    wr8(16'h838, 64'h40, 0, "R11 busy set t7");
  endtask

  task automatic t_alias();
    rd_expect(16'hA10, 6'd7, 64'h40, "R12 alias busy cpu7");
    rd_expect(16'hA10, 6'd9, 64'd0, "R12 alias busy cpu9");
    wr8(16'hA10, 64'h40, 6'd8, "R12 alias write cpu8");
    rd_expect(16'h840, 0, 64'h40, "R12 direct sees alias write");
    rd_expect(16'h838, 0, 64'h40, "R12 other entry kept");
    rd_expect(16'hA00, 6'd8, 64'd0, "R12 alias data0");
    rd_expect(16'hA08, 6'd8, 64'd0, "R12 alias data1");
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_unmapped();
    t_intman();
    t_vec();
    t_readonly();
    t_bank_hash();
    t_enables();
    t_status();
    t_syndrome();
    t_busy();
    t_alias();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule